// File: doc/BRIEF.md
# Stack Push Datapath Controller

This block is a small non-pipelined datapath with its own cycle controller. It executes one instruction: push one of two 8-bit data registers, A or B, onto a descending memory stack. The stack pointer is 16 bits wide. A push writes the chosen register to the memory word that the stack pointer addresses, then lowers the stack pointer by one.

A one-cycle start strobe together with a one-bit register select begins a push. All memory traffic passes through an address register and a data register, and the memory write lasts two clock cycles. The stack pointer has its own local decrementer, which works alongside the write. As a result, every push takes exactly three cycles, and the block shows that the push is over with a one-cycle done pulse.

A shared load port sets the two data registers and the stack pointer while the block is idle. The memory side is a plain synchronous write port with an address, write data and a write enable.

Top module: `stack_push_ctrl`

## Requirements
- R1: After reset, busy, mem_we and done are 0 and sp_out equals the reset stack pointer value 0xFFFF.
- R2: If start is 1 at a rising edge while the block is idle, the next cycle is a capture cycle with busy=1 and mem_we=0. At the end of that cycle the address register takes the stack pointer value and the data register takes A when reg_sel was 0, or B when reg_sel was 1. reg_sel is sampled at the same edge as start.
- R3: In the two cycles after the capture cycle, mem_we is 1, mem_addr holds the stack pointer value from before the push, and mem_wdata holds the captured register. Neither changes between the two cycles.
- R4: done is 1 only in the second write cycle, which is the third cycle of the push. In the cycle after it, busy, done and mem_we are 0.
- R5: The stack pointer decreases by exactly one at the end of the third push cycle, and 0x0000 wraps to 0xFFFF.
- R6: A start strobe that arrives while busy=1 is ignored. It starts no further push and does not change the stack pointer.
- R7: With ld_en=1 while idle, ld_target selects the destination: 0 selects A, 1 selects B, 2 selects the stack pointer, and 3 selects nothing. A and B take ld_data[7:0], and the stack pointer takes ld_data[15:0]. The load takes effect at the next edge. A load requested while busy=1 is ignored.
- R8: A start in the idle cycle right after done begins a new push at once, and that push uses the decremented stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Push request strobe |
| reg_sel | input | 1 | Register to push: 0 = A, 1 = B |
| ld_en | input | 1 | Load strobe for A, B or the stack pointer |
| ld_target | input | 2 | Load destination: 0 A, 1 B, 2 stack pointer, 3 none |
| ld_data | input | 16 | Load value |
| mem_addr | output | 16 | Memory address, driven from the address register |
| mem_wdata | output | 8 | Memory write data, driven from the data register |
| mem_we | output | 1 | Memory write enable |
| busy | output | 1 | A push is in progress |
| done | output | 1 | One-cycle pulse in the last push cycle |
| sp_out | output | 16 | Current stack pointer |

## Verification
The main sweep pushes all 256 byte values. On each push it loads different values into A and B and alternates the register select, so a swapped or stuck bus multiplexer shows up as the wrong byte on mem_wdata. Over the same sweep the address falls one step per push, which separates a decrement applied once per push from one that is missing or applied twice. Three more patterns cover the remaining cases. A stack pointer of 1 pushed three times back to back exercises the wrap through zero and the immediate restart. Start strobes sent in the middle of a push check that a busy block ignores them. Loads of A and of the stack pointer sent in the middle of a push are compared with the values seen on the following push, which shows that loads are blocked while busy.

// File: rtl/stack_push_pkg.sv
package stack_push_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_CAPTURE = 2'd1,
    PH_WRITE0  = 2'd2,
    PH_WRITE1  = 2'd3
  } push_phase_e;

  localparam logic [1:0] TGT_A  = 2'd0;
  localparam logic [1:0] TGT_B  = 2'd1;
  localparam logic [1:0] TGT_SP = 2'd2;

  localparam int NUM_GPR = 2;

  function automatic push_phase_e phase_after(push_phase_e cur, logic go);
    case (cur)
      PH_IDLE:    return go ? PH_CAPTURE : PH_IDLE;
      PH_CAPTURE: return PH_WRITE0;
      PH_WRITE0:  return PH_WRITE1;
      default:    return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/push_sequencer.sv
module push_sequencer
  import stack_push_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic capture,
  output logic write_act,
  output logic finish,
  output logic busy
);

  push_phase_e phase_q;

  assign accept    = start && (phase_q == PH_IDLE);
  assign capture   = (phase_q == PH_CAPTURE);
  assign write_act = (phase_q == PH_WRITE0) || (phase_q == PH_WRITE1);
  assign finish    = (phase_q == PH_WRITE1);
  assign busy      = (phase_q != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_after(phase_q, start);
  end

endmodule

// File: rtl/push_datapath.sv
module push_datapath
  import stack_push_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_GPR-1:0] gpr_ld,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              accept,
  input  logic              reg_sel,
  input  logic              capture,
  input  logic [ADDR_W-1:0] sp_val,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr
);

  logic [DATA_W-1:0] gpr_q [NUM_GPR];
  logic              sel_q;
  logic [DATA_W-1:0] bus;

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (!rst_n)        gpr_q[g] <= '0;
      else if (gpr_ld[g]) gpr_q[g] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (accept) sel_q <= reg_sel;
  end

  assign bus = gpr_q[sel_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mar <= '0;
      mdr <= '0;
    end else if (capture) begin
      mar <= sp_val;
      mdr <= bus;
    end
  end

endmodule

// File: rtl/stack_pointer_unit.sv
module stack_pointer_unit #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SP_RESET = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_data,
  input  logic              dec_en,
  output logic [ADDR_W-1:0] sp
);

  function automatic logic [ADDR_W-1:0] sp_down(logic [ADDR_W-1:0] v);
    return v - ADDR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      sp <= SP_RESET;
    else if (dec_en) sp <= sp_down(sp);
    else if (ld_en)  sp <= ld_data;
  end

endmodule

// File: rtl/stack_push_ctrl.sv
module stack_push_ctrl
  import stack_push_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SP_RESET = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              reg_sel,
  input  logic              ld_en,
  input  logic [1:0]        ld_target,
  input  logic [ADDR_W-1:0] ld_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] sp_out
);

  logic accept_evt;
  logic capture_evt;
  logic write_evt;
  logic finish_evt;
  logic idle_ld;
  logic [NUM_GPR-1:0] gpr_ld;
  logic sp_ld;

  assign idle_ld   = ld_en && !busy;
  assign gpr_ld[0] = idle_ld && (ld_target == TGT_A);
  assign gpr_ld[1] = idle_ld && (ld_target == TGT_B);
  assign sp_ld     = idle_ld && (ld_target == TGT_SP);

  push_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .accept    (accept_evt),
    .capture   (capture_evt),
    .write_act (write_evt),
    .finish    (finish_evt),
    .busy      (busy)
  );

  push_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .gpr_ld  (gpr_ld),
    .ld_data (ld_data[DATA_W-1:0]),
    .accept  (accept_evt),
    .reg_sel (reg_sel),
    .capture (capture_evt),
    .sp_val  (sp_out),
    .mar     (mem_addr),
    .mdr     (mem_wdata)
  );

  stack_pointer_unit #(.ADDR_W(ADDR_W), .SP_RESET(SP_RESET)) u_sp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (sp_ld),
    .ld_data (ld_data),
    .dec_en  (finish_evt),
    .sp      (sp_out)
  );

  assign mem_we = write_evt;
  assign done   = finish_evt;

endmodule

// File: rtl/stack_push_checker.sv
module stack_push_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              capture_evt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] sp_out
);

  AST_CAPTURE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> (mem_addr == $past(sp_out)) && mem_we); // R2

  AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !done) |=> mem_we && done && $stable(mem_addr) && $stable(mem_wdata)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy && !mem_we); // R4

  AST_SP_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> sp_out == ADDR_W'($past(sp_out) - ADDR_W'(1))); // R5

  AST_SP_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(sp_out)); // R7

  AST_WE_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R6

endmodule

bind stack_push_ctrl stack_push_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .capture_evt (capture_evt),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_we      (mem_we),
  .busy        (busy),
  .done        (done),
  .sp_out      (sp_out)
);

// File: tb/stack_push_ctrl_tb_top.sv
`timescale 1ns/1ps
module stack_push_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, reg_sel, ld_en;
  logic [1:0]  ld_target;
  logic [15:0] ld_data;
  logic [15:0] mem_addr, sp_out;
  logic [7:0]  mem_wdata;
  logic        mem_we, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  stack_push_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_sel(reg_sel),
    .ld_en(ld_en), .ld_target(ld_target), .ld_data(ld_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .busy(busy), .done(done), .sp_out(sp_out)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Called at a falling edge; leaves the bench at the next falling edge.
  task automatic load(input logic [1:0] t, input logic [15:0] d);
    ld_en = 1'b1; ld_target = t; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Called at a falling edge in an idle cycle; returns at the falling edge
  // of the idle cycle after done.
  task automatic do_push(input logic sel, input logic [7:0] ed,
                         input logic [15:0] ea, input bit poke,
                         input logic [1:0] ptgt);
    logic [15:0] nxt;
    nxt = ea - 16'd1;
    start = 1'b1; reg_sel = sel;
    @(negedge clk);
    start = poke; reg_sel = ~sel;
    ld_en = poke; ld_target = ptgt; ld_data = 16'h12EE;
    chk(busy === 1'b1 && mem_we === 1'b0, "R2", "capture busy/we",
        {busy, mem_we}, 2'b10);
    @(negedge clk);
    chk(mem_we === 1'b1, "R3", "we write0", mem_we, 1);
    chk(mem_addr === ea, "R2", "addr", mem_addr, ea);
    chk(mem_wdata === ed, "R2", "wdata", mem_wdata, ed);
    chk(done === 1'b0, "R4", "done early", done, 0);
    @(negedge clk);
    chk(mem_we === 1'b1 && mem_addr === ea && mem_wdata === ed, "R3",
        "write1 hold", {mem_addr, mem_wdata}, {ea, ed});
    chk(done === 1'b1, "R4", "done", done, 1);
    chk(sp_out === ea, "R5", "sp before dec", sp_out, ea);
    start = 1'b0; ld_en = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mem_we === 1'b0, poke ? "R6" : "R4",
        "idle after", {busy, done, mem_we}, 0);
    chk(sp_out === nxt, poke ? "R7" : "R5", "sp after", sp_out, nxt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  av, bv;
    logic [15:0] ea;
    rst_n = 1'b0; start = 1'b0; reg_sel = 1'b0;
    ld_en = 1'b0; ld_target = 2'd3; ld_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(busy === 0 && mem_we === 0 && done === 0, "R1", "reset flags",
        {busy, mem_we, done}, 0);
    chk(sp_out === 16'hFFFF, "R1", "reset sp", sp_out, 16'hFFFF);

    // R7 idle loads
    load(2'd2, 16'h8000);
    chk(sp_out === 16'h8000, "R7", "sp load", sp_out, 16'h8000);
    load(2'd3, 16'h0042);
    chk(sp_out === 16'h8000, "R7", "target 3 no effect", sp_out, 16'h8000);

    // Main sweep over all byte values, alternating the selected register
    for (int i = 0; i < 256; i++) begin
      av = 8'(i);
      bv = 8'(i) ^ 8'hA5;
      ea = 16'h8000 - 16'(i);
      load(2'd0, {8'h00, av});
      load(2'd1, {8'hFF, bv});
      do_push(i[0], i[0] ? bv : av, ea, 1'b0, 2'd3);
    end

    // R5/R8 wrap through zero with back-to-back pushes
    load(2'd0, 16'h003C);
    load(2'd2, 16'h0001);
    do_push(1'b0, 8'h3C, 16'h0001, 1'b0, 2'd3);
    do_push(1'b0, 8'h3C, 16'h0000, 1'b0, 2'd3);
    chk(sp_out === 16'hFFFF, "R5", "wrap", sp_out, 16'hFFFF);
    do_push(1'b0, 8'h3C, 16'hFFFF, 1'b0, 2'd3); // R8 immediate restart

    // R6/R7 start and stack-pointer load while busy are ignored
    load(2'd2, 16'h4000);
    do_push(1'b0, 8'h3C, 16'h4000, 1'b1, 2'd2);
    // R7 load of A while busy is ignored: next push still sees old A
    do_push(1'b0, 8'h3C, 16'h3FFF, 1'b1, 2'd0);
    do_push(1'b0, 8'h3C, 16'h3FFE, 1'b0, 2'd3);
    @(negedge clk);
    chk(busy === 0 && sp_out === 16'h3FFD, "R6", "no stray push",
        {busy, sp_out}, 16'h3FFD);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule